// File: doc/BRIEF.md
# Multiplexed Three-State Parallel Bus Master

This block turns single internal read and write requests into a classic multiplexed parallel bus cycle. Each request carries a 16-bit address, a byte of write data, a direction bit and a space bit. The space bit selects memory space or I/O space.

The block runs every access as a fixed sequence of three clock states, T1, T2 and T3. In T1 the low address byte goes out on the shared data lines while an address latch enable pulse marks it, so that outside logic can hold it. In T2 exactly one of two active-low strobes is asserted. A read releases the data lines so that the target can drive them. A write drives the write data. In T3 the strobe returns high.

Read data is captured as the read strobe rises. A one-cycle done pulse follows T3. A request that is waiting while T3 is in progress starts its own T1 immediately, with no idle state in between.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, with no request pending: bus_iom is 0 (memory), bus_rd_n and bus_wr_n are 1, bus_oe, bus_ale and done are 0, and req_ready is 1.
- R2: A request seen at a clock edge while the block is idle starts T1 on the next cycle. After T1 come T2 and then T3, one clock each. req_ready is 1 only while idle or in T3.
- R3: In T1, bus_ale is 1, bus_dout carries address bits [7:0], bus_oe is 1 and both strobes are high. bus_ale is 0 in every other cycle.
- R4: From T1 through T3, bus_addr_hi carries address bits [15:8] for a memory access (req_io=0) and all zeros for an I/O access (req_io=1), because only the low 8 address bits count in I/O space. Outside a cycle, bus_addr_hi is 0.
- R5: bus_iom is 1 for an I/O access and 0 for a memory access, and it holds that value from T1 through T3. It is 0 when idle.
- R6: On a read (req_write=0), bus_rd_n is low in T2 only, and bus_oe is 0 in T2 and T3. The value on bus_din at the end of T2 appears on rd_data in the done cycle.
- R7: On a write (req_write=1), bus_wr_n is low in T2 only, so it rises at the start of T3. bus_dout carries the write data with bus_oe at 1 through both T2 and T3.
- R8: bus_rd_n and bus_wr_n are never low at the same time.
- R9: done is high for exactly one cycle, the cycle right after T3.
- R10: A request held while T3 is in progress is accepted, and its T1 begins in the next cycle, the same cycle as the done pulse of the previous access.
- R11: Changes on the request inputs after acceptance leave the cycle in progress unaffected: address, data, direction and space stay as accepted until T3 ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request is accepted at this edge if req_valid is set |
| rd_data | output | 8 | Captured read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| bus_addr_hi | output | 8 | Upper address lines |
| bus_ale | output | 1 | Address latch enable, high in T1 |
| bus_iom | output | 1 | Space qualifier, 1 = I/O |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 8 | Data lines driven by the master |
| bus_oe | output | 1 | Master drives the data lines when 1 |
| bus_din | input | 8 | Data lines as seen from the bus |

## Verification
A request driven before edge P0 puts T1 on the ports in the cycle after P0, then T2 after P1 and T3 after P2. done and rd_data follow after P3, because the read byte is registered on the edge that ends T2 and done is registered on the edge that ends T3.

The bench drives all inputs and samples all outputs on the falling edge. It walks cycle by cycle through every access and checks each phase's outputs in the half-cycle where they are due. The model target places its read byte on bus_din during T2, computed from the accepted address, so the byte is present at the capturing edge.

A sweep covers both directions, both spaces and a spread of addresses. A chained pair confirms that the next T1 coincides with the done pulse.

// File: rtl/mbm_pkg.sv
// Package: shared types for the multiplexed bus master.
// Assumes: nothing beyond a single clock domain.
package mbm_pkg;
    // Bus state of the master: idle or one of the three clock states of a cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_T1   = 2'd1,
        PH_T2   = 2'd2,
        PH_T3   = 2'd3
    } phase_t;
endpackage

// File: rtl/mbm_phase_seq.sv
// Module: mbm_phase_seq
// Steps the master through IDLE -> T1 -> T2 -> T3 and accepts requests
// when idle or in T3 (the latter gives back-to-back cycles).
// Assumes: req_valid is synchronous to clk.
module mbm_phase_seq
    import mbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    output phase_t phase,
    output logic   ready,
    output logic   accept
);

    // Request window: idle, or the last state of a cycle.
    always_comb begin
        ready  = (phase == PH_IDLE) || (phase == PH_T3);
        accept = ready && req_valid;
    end

    // State register: advance one state per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: phase <= req_valid ? PH_T1 : PH_IDLE;
                PH_T1:   phase <= PH_T2;
                PH_T2:   phase <= PH_T3;
                PH_T3:   phase <= req_valid ? PH_T1 : PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |=> (phase == PH_T2));
    p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2) |=> (phase == PH_T3));
    p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && req_valid) |=> (phase == PH_T1));

endmodule

// File: rtl/mbm_req_hold.sv
// Module: mbm_req_hold
// Holds the accepted request for the duration of its bus cycle, so that
// the request inputs may change freely once the request is accepted.
// Assumes: accept pulses only in the request window.
module mbm_req_hold
    import mbm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  phase_t        phase,
    input  logic          in_write,
    input  logic          in_io,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    output logic          h_write,
    output logic          h_io,
    output logic [AW-1:0] h_addr,
    output logic [DW-1:0] h_wdata
);

    // Capture register: load the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_write <= 1'b0;
            h_io    <= 1'b0;
            h_addr  <= '0;
            h_wdata <= '0;
        end else if (accept) begin
            h_write <= in_write;
            h_io    <= in_io;
            h_addr  <= in_addr;
            h_wdata <= in_wdata;
        end
    end

    p_hold_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 || phase == PH_T3) |-> $stable(h_addr));
    p_hold_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 || phase == PH_T3) |-> ($stable(h_write) && $stable(h_io)));

endmodule

// File: rtl/mbm_bus_drive.sv
// Module: mbm_bus_drive
// Decodes the bus pins from the current state and the held request:
// ALE and low address in T1, one strobe in T2, data hold in T3.
// Assumes: IOW <= AW; I/O accesses keep only the low IOW address bits.
module mbm_bus_drive
    import mbm_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int IOW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic             h_write,
    input  logic             h_io,
    input  logic [AW-1:0]    h_addr,
    input  logic [DW-1:0]    h_wdata,
    output logic [AW-DW-1:0] addr_hi,
    output logic             ale,
    output logic             iom,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    dout,
    output logic             oe
);

    localparam int HW = AW - DW;

    // Upper-line mask for I/O space: keep only bits below IOW.
    function automatic logic [HW-1:0] io_mask_f();
        logic [HW-1:0] m;
        for (int k = 0; k < HW; k++) begin
            m[k] = ((k + DW) < IOW);
        end
        return m;
    endfunction

    localparam logic [HW-1:0] IO_MASK = io_mask_f();

    logic [HW-1:0] hi_val;
    logic          in_cycle;

    // Upper address value for the held request.
    always_comb begin
        hi_val   = h_addr[AW-1:DW] & (h_io ? IO_MASK : {HW{1'b1}});
        in_cycle = (phase != PH_IDLE);
    end

    // Pin decode: one arm per bus state.
    always_comb begin
        addr_hi = in_cycle ? hi_val : '0;
        iom     = in_cycle ? h_io : 1'b0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        dout    = '0;
        oe      = 1'b0;
        case (phase)
            PH_T1: begin
                ale  = 1'b1;
                dout = h_addr[DW-1:0];
                oe   = 1'b1;
            end
            PH_T2: begin
                if (h_write) begin
                    wr_n = 1'b0;
                    dout = h_wdata;
                    oe   = 1'b1;
                end else begin
                    rd_n = 1'b0;
                end
            end
            PH_T3: begin
                if (h_write) begin
                    dout = h_wdata;
                    oe   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !oe);
    p_rd_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n);
    p_wr_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (wr_n && oe && $stable(dout)));
    p_ale_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && oe));
    p_iom_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && in_cycle) |-> $stable(iom));

endmodule

// File: rtl/mbm_rd_capture.sv
// Module: mbm_rd_capture
// Registers the read byte on the edge that ends T2 (the read strobe rises
// there) and raises done in the cycle after T3.
// Assumes: bus_din is stable around the edge that ends T2.
module mbm_rd_capture
    import mbm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic          h_write,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rd_data,
    output logic          done
);

    // Read data register: sample the bus at the strobe's rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (phase == PH_T2 && !h_write) begin
            rd_data <= din;
        end
    end

    // Completion pulse: one cycle after T3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (phase == PH_T3);
        end
    end

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_stable_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3) |=> $stable(rd_data));

endmodule

// File: rtl/mux_bus_master.sv
// Module: mux_bus_master
// Top of the multiplexed three-state bus master. Internal requests become
// T1/T2/T3 bus cycles with the low address multiplexed on the data lines.
// Assumes: targets respond within T2 (no wait states); one clock domain.
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int IO_ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_io,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     done,
    output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
    output logic                     bus_ale,
    output logic                     bus_iom,
    output logic                     bus_rd_n,
    output logic                     bus_wr_n,
    output logic [DATA_W-1:0]        bus_dout,
    output logic                     bus_oe,
    input  logic [DATA_W-1:0]        bus_din
);

    phase_t              phase;
    logic                accept;
    logic                h_write;
    logic                h_io;
    logic [ADDR_W-1:0]   h_addr;
    logic [DATA_W-1:0]   h_wdata;

    mbm_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .phase     (phase),
        .ready     (req_ready),
        .accept    (accept)
    );

    mbm_req_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .phase    (phase),
        .in_write (req_write),
        .in_io    (req_io),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .h_write  (h_write),
        .h_io     (h_io),
        .h_addr   (h_addr),
        .h_wdata  (h_wdata)
    );

    mbm_bus_drive #(.AW(ADDR_W), .DW(DATA_W), .IOW(IO_ADDR_W)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .h_write (h_write),
        .h_io    (h_io),
        .h_addr  (h_addr),
        .h_wdata (h_wdata),
        .addr_hi (bus_addr_hi),
        .ale     (bus_ale),
        .iom     (bus_iom),
        .rd_n    (bus_rd_n),
        .wr_n    (bus_wr_n),
        .dout    (bus_dout),
        .oe      (bus_oe)
    );

    mbm_rd_capture #(.DW(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .h_write (h_write),
        .din     (bus_din),
        .rd_data (rd_data),
        .done    (done)
    );

    p_ale_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_ale);
    p_done_follows_t3_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == PH_T3));
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!bus_iom && bus_rd_n && bus_wr_n && !bus_oe));

endmodule

// File: tb/sim_mux_bus_master.sv
`timescale 1ns/1ps
module sim_mux_bus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  bus_din = '0;
    logic        req_ready, done, bus_ale, bus_iom, bus_rd_n, bus_wr_n, bus_oe;
    logic [7:0]  rd_data, bus_addr_hi, bus_dout;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mux_bus_master u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_data(rd_data), .done(done),
        .bus_addr_hi(bus_addr_hi), .bus_ale(bus_ale), .bus_iom(bus_iom),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] tgt_byte(input logic [15:0] a);
        return (a[7:0] ^ 8'h3C) + a[15:8];
    endfunction

    function automatic logic [7:0] exp_hi(input logic io, input logic [15:0] a);
        return io ? 8'h00 : a[15:8];
    endfunction

    // Idle-state checks (R1, R3, R5).
    task automatic chk_idle(input string tag);
        chk({tag, " R1 rd_n"}, bus_rd_n, 1'b1);
        chk({tag, " R1 wr_n"}, bus_wr_n, 1'b1);
        chk({tag, " R1 oe"}, bus_oe, 1'b0);
        chk({tag, " R3 ale"}, bus_ale, 1'b0);
        chk({tag, " R5 iom"}, bus_iom, 1'b0);
        chk({tag, " R1 ready"}, req_ready, 1'b1);
    endtask

    // One full access from idle; inputs scrambled after acceptance (R11).
    task automatic access(input logic wr, input logic io, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = d;
        @(negedge clk); // T1
        req_valid = 1'b0; req_write = ~wr; req_io = ~io; req_addr = ~a; req_wdata = ~d;
        chk("R3 ale T1", bus_ale, 1'b1);
        chk("R3 dout T1", bus_dout, a[7:0]);
        chk("R3 oe T1", bus_oe, 1'b1);
        chk("R3 strobes T1", {bus_rd_n, bus_wr_n}, 2'b11);
        chk("R4 hi T1", bus_addr_hi, exp_hi(io, a));
        chk("R5 iom T1", bus_iom, io);
        chk("R2 ready T1", req_ready, 1'b0);
        @(negedge clk); // T2
        chk("R11 R4 hi T2", bus_addr_hi, exp_hi(io, a));
        chk("R5 iom T2", bus_iom, io);
        chk("R3 ale T2", bus_ale, 1'b0);
        chk("R2 ready T2", req_ready, 1'b0);
        if (wr) begin
            chk("R7 strobes T2", {bus_rd_n, bus_wr_n}, 2'b10);
            chk("R7 R11 dout T2", bus_dout, d);
            chk("R7 oe T2", bus_oe, 1'b1);
        end else begin
            chk("R6 strobes T2", {bus_rd_n, bus_wr_n}, 2'b01);
            chk("R6 oe T2", bus_oe, 1'b0);
            bus_din = tgt_byte(a);
        end
        @(negedge clk); // T3
        bus_din = 8'hEE;
        chk("R8 R6 R7 strobes T3", {bus_rd_n, bus_wr_n}, 2'b11);
        chk("R4 hi T3", bus_addr_hi, exp_hi(io, a));
        chk("R5 iom T3", bus_iom, io);
        chk("R2 ready T3", req_ready, 1'b1);
        chk("R9 done T3", done, 1'b0);
        if (wr) begin
            chk("R7 oe T3", bus_oe, 1'b1);
            chk("R7 dout T3", bus_dout, d);
        end else begin
            chk("R6 oe T3", bus_oe, 1'b0);
        end
        @(negedge clk); // done cycle
        chk("R9 done", done, 1'b1);
        if (!wr) chk("R6 rd_data", rd_data, tgt_byte(a));
        chk("R4 hi idle", bus_addr_hi, 8'h00);
        chk_idle("post");
        @(negedge clk);
        chk("R9 done gone", done, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("reset");
        chk("R1 done", done, 1'b0);
        chk("R4 hi reset", bus_addr_hi, 8'h00);

        // Sweep: direction x space x addresses.
        for (int wr = 0; wr < 2; wr++) begin
            for (int io = 0; io < 2; io++) begin
                for (int i = 0; i < 12; i++) begin
                    logic [15:0] a;
                    a = 16'(i * 16'h2493) ^ 16'(i << 12) ^ 16'h8001;
                    access(wr[0], io[0], a, a[7:0] ^ a[15:8] ^ 8'hA5);
                end
            end
        end

        // Back-to-back: read A, then write B held during A (R10, R2, R11).
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0; req_addr = 16'hC35A;
        @(negedge clk); // A T1
        req_write = 1'b1; req_io = 1'b1; req_addr = 16'h7E81; req_wdata = 8'h96;
        chk("R10 A ale", bus_ale, 1'b1);
        chk("R10 A dout", bus_dout, 8'h5A);
        @(negedge clk); // A T2
        chk("R11 A hi held", bus_addr_hi, 8'hC3);
        chk("R11 A still read", {bus_rd_n, bus_wr_n}, 2'b01);
        chk("R2 ready A T2", req_ready, 1'b0);
        bus_din = tgt_byte(16'hC35A);
        @(negedge clk); // A T3
        chk("R2 ready A T3", req_ready, 1'b1);
        @(negedge clk); // B T1 with A done
        req_valid = 1'b0;
        chk("R10 A done", done, 1'b1);
        chk("R10 A rd_data", rd_data, tgt_byte(16'hC35A));
        chk("R10 B ale", bus_ale, 1'b1);
        chk("R10 B dout", bus_dout, 8'h81);
        chk("R10 B iom", bus_iom, 1'b1);
        chk("R10 B hi", bus_addr_hi, 8'h00);
        @(negedge clk); // B T2
        chk("R10 B wr", {bus_rd_n, bus_wr_n}, 2'b10);
        chk("R10 B data", bus_dout, 8'h96);
        chk("R9 done single", done, 1'b0);
        @(negedge clk); // B T3
        @(negedge clk);
        chk("R10 B done", done, 1'b1);
        chk_idle("b2b end");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule